// File: doc/BRIEF.md
# Dual-Channel Prescaled Pulse-Width Generator

This block produces two pulse-width modulated outputs, A and B, from a single free-running counter. The counter advances on enable pulses from a prescaler. A 3-bit select code picks either one of seven power-of-two divisions of the system clock or the rising edges of an external clock input, which is first brought into the clock domain. Each channel compares an 8-bit duty value with a slice of the shared counter. A per-channel mode bit chooses a short period (low counter byte) or a long period (a byte taken seven bits higher). Duty values pass through a holding register and take effect only when a period begins.

Software can override either pin to a static level. Channel A can instead carry the square wave of the selected counter clock, which makes the prescaler rate visible at the pin. All settings come in through a small synchronous write port with four addresses.

Top module: `dual_pwm`

## Requirements
- R1: The counter advances by one once every 2^(code+1) system clocks for select codes 0 to 6. For code 7 it advances once per rising edge of `ext_clk`, counted after a two-flop synchronizer and an edge detector.
- R2: With a channel's slow bit at 0, its period is 2^DUTY_W counter increments and its compare field is counter bits [DUTY_W-1:0].
- R3: With a channel's slow bit at 1, its period is 2^(DUTY_W+SLOW_SHIFT) increments and its compare field is counter bits [SLOW_SHIFT+DUTY_W-1:SLOW_SHIFT].
- R4: The PWM level is high while the compare field is below the active duty and low from the count equal to the duty until the period ends. A duty of 0 gives a constant low.
- R5: A written duty is held and becomes active only on the counter step that starts a new period of that channel. A period already in progress keeps its old duty.
- R6: When force-A (control bit 0 at address 1) is set, `pwm_a` carries level-A (bit 1). This takes priority over both PWM and clock-out mode. A set level bit gives 1, a clear level bit gives 0.
- R7: When force-B (bit 2 at address 1) is set, `pwm_b` carries level-B (bit 3) in place of its PWM level.
- R8: When clock-out (bit 3 at address 0) is set and A is not forced, `pwm_a` carries the selected counter clock. For codes 0 to 6 this is divider bit `code`, a square wave with period 2^(code+1). For code 7 it is the synchronized external clock.
- R9: During reset and after it, both pins are low and every register is zero. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R10: Address 0 holds the select code in bits [2:0], clock-out in bit 3, slow-A in bit 4 and slow-B in bit 5. Address 2 holds the duty of A and address 3 the duty of B. A write takes effect at the clock edge that samples `wr_en`.
- R11: Each pin is registered, so a change of counter, setting or override shows at the pin one clock after the edge that updated it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External counter clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The bench builds the block with DUTY_W of 4 and SLOW_SHIFT of 3. This gives a 16-increment short period and a 128-increment long period, so every select code, including the slowest divide-by-128 tap, completes more than one long period within the run. A cycle-accurate arithmetic model of the prescaler, counter, holding registers and output mux is compared with both pins on every clock. Duty writes land at arbitrary points inside periods, and all sixteen override patterns are crossed with clock-out on and off. Fixed-window high-time counts give independent checks of pulse width, clock-out rate and forced levels.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int REG_W     = 8;
  localparam int PSEL_W    = 3;
  localparam int NUM_TAPS  = (2 ** PSEL_W) - 1;

  typedef enum logic [1:0] {
    ADDR_CFG    = 2'd0,
    ADDR_OVR    = 2'd1,
    ADDR_DUTY_A = 2'd2,
    ADDR_DUTY_B = 2'd3
  } pwm_addr_e;

  // Address 0 layout, MSB first: slow_b(5) slow_a(4) clk_out(3) psel(2:0)
  typedef struct packed {
    logic              slow_b;
    logic              slow_a;
    logic              clk_out;
    logic [PSEL_W-1:0] psel;
  } pwm_cfg_t;

  // Address 1 layout, MSB first: lvl_b(3) frc_b(2) lvl_a(1) frc_a(0)
  typedef struct packed {
    logic lvl_b;
    logic frc_b;
    logic lvl_a;
    logic frc_a;
  } pwm_ovr_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick,
  output logic              clk_mon
);

  localparam int SEL_N = 2 ** PSEL_W;
  localparam logic [NUM_TAPS-1:0] DIV_ONE = NUM_TAPS'(1);

  logic [NUM_TAPS-1:0] div_q, div_d;
  logic                ext_s1_q, ext_s2_q, ext_s3_q;
  logic                ext_pulse;
  logic [SEL_N-1:0]    sel_tick;
  logic [SEL_N-1:0]    sel_lvl;

  // next state
  always_comb begin
    div_d = div_q + DIV_ONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      ext_s1_q <= 1'b0;
      ext_s2_q <= 1'b0;
      ext_s3_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      ext_s1_q <= ext_clk;
      ext_s2_q <= ext_s1_q;
      ext_s3_q <= ext_s2_q;
    end
  end

  assign ext_pulse = ext_s2_q & ~ext_s3_q;

  // one tap per divider stage: pulse when the low k+1 bits are all ones
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign sel_tick[k] = &div_q[k:0];
    assign sel_lvl[k]  = div_q[k];
  end
  assign sel_tick[NUM_TAPS] = ext_pulse;
  assign sel_lvl[NUM_TAPS]  = ext_s2_q;

  assign tick    = sel_tick[psel];
  assign clk_mon = sel_lvl[psel];

  // R1
  div2_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psel == '0) |=> (!tick || psel != '0));

  // R1
  ext_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pulse |=> !ext_pulse);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DUTY_W     = 8,
  parameter int SLOW_SHIFT = 7,
  parameter int CNT_W      = 16,
  parameter bit HAS_MON    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              slow,
  input  logic              duty_wr,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              frc,
  input  logic              lvl,
  input  logic              mon_en,
  input  logic              mon_lvl,
  output logic              pin
);

  localparam int SLOW_TOP = SLOW_SHIFT + DUTY_W - 1;

  logic [DUTY_W-1:0] shd_q, shd_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              pin_q, pin_d;
  logic [DUTY_W-1:0] field;
  logic              bnd;
  logic              load;
  logic              pwm_lvl;
  logic              mon_sel;
  logic              unused_cnt;

  assign unused_cnt = ^{cnt_q, cnt_nxt};

  if (HAS_MON) begin : g_mon
    assign mon_sel = mon_en;
  end else begin : g_nomon
    logic unused_mon;
    assign unused_mon = mon_en ^ mon_lvl;
    assign mon_sel    = 1'b0;
  end

  always_comb begin
    field   = slow ? cnt_q[SLOW_TOP -: DUTY_W] : cnt_q[DUTY_W-1:0];
    bnd     = slow ? (cnt_nxt[SLOW_TOP:0] == '0) : (cnt_nxt[DUTY_W-1:0] == '0);
    load    = tick & bnd;
    pwm_lvl = (field < act_q);
  end

  // next state
  always_comb begin
    shd_d = duty_wr ? duty_in : shd_q;
    act_d = load ? shd_q : act_q;
    if (frc) begin
      pin_d = lvl;
    end else if (mon_sel) begin
      pin_d = mon_lvl;
    end else begin
      pin_d = pwm_lvl;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
      pin_q <= 1'b0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;

  // R5
  duty_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));

  // R6 R7
  force_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> (pin_q == $past(lvl)));

  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0 && !frc && !mon_sel) |=> !pin_q);

endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
  import pwm_pkg::*;
#(
  parameter int DUTY_W     = 8,
  parameter int SLOW_SHIFT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             pwm_a,
  output logic             pwm_b
);

  localparam int CNT_W = DUTY_W + SLOW_SHIFT + 1;
  localparam int CFG_W = $bits(pwm_cfg_t);
  localparam int OVR_W = $bits(pwm_ovr_t);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic       rst_s1_q, rst_s2_q;
  logic       rst_i_n;
  pwm_cfg_t   cfg_q, cfg_d;
  pwm_ovr_t   ovr_q, ovr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nxt;
  logic       tick;
  logic       clk_mon;
  logic [1:0] pin;
  logic       unused_wr;

  assign unused_wr = ^wr_data;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  // register port, next state
  always_comb begin
    cfg_d = cfg_q;
    ovr_d = ovr_q;
    if (wr_en && wr_addr == ADDR_CFG) begin
      cfg_d = pwm_cfg_t'(wr_data[CFG_W-1:0]);
    end
    if (wr_en && wr_addr == ADDR_OVR) begin
      ovr_d = pwm_ovr_t'(wr_data[OVR_W-1:0]);
    end
  end

  // shared counter, next state
  always_comb begin
    cnt_nxt = cnt_q + CNT_ONE;
    cnt_d   = tick ? cnt_nxt : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q <= '0;
      ovr_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      ovr_q <= ovr_d;
      cnt_q <= cnt_d;
    end
  end

  pwm_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .ext_clk (ext_clk),
    .psel    (cfg_q.psel),
    .tick    (tick),
    .clk_mon (clk_mon)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic ch_slow, ch_frc, ch_lvl, ch_wr;
    assign ch_slow = (ch == 0) ? cfg_q.slow_a : cfg_q.slow_b;
    assign ch_frc  = (ch == 0) ? ovr_q.frc_a  : ovr_q.frc_b;
    assign ch_lvl  = (ch == 0) ? ovr_q.lvl_a  : ovr_q.lvl_b;
    assign ch_wr   = wr_en && (wr_addr == ((ch == 0) ? ADDR_DUTY_A : ADDR_DUTY_B));

    pwm_channel #(
      .DUTY_W     (DUTY_W),
      .SLOW_SHIFT (SLOW_SHIFT),
      .CNT_W      (CNT_W),
      .HAS_MON    (ch == 0)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .tick    (tick),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .slow    (ch_slow),
      .duty_wr (ch_wr),
      .duty_in (wr_data[DUTY_W-1:0]),
      .frc     (ch_frc),
      .lvl     (ch_lvl),
      .mon_en  (cfg_q.clk_out),
      .mon_lvl (clk_mon),
      .pin     (pin[ch])
    );
  end

  assign pwm_a = pin[0];
  assign pwm_b = pin[1];

  // R1
  cnt_holds_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tick |=> $stable(cnt_q));

  // R9
  reset_pins_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b));

endmodule

// File: tb/dual_pwm_test.sv
`timescale 1ns/1ps
module dual_pwm_test;

  localparam int DW = 4;
  localparam int SS = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_clk;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       pwm_a, pwm_b;

  int vectors = 0;
  int miscompares = 0;
  bit cmp_on = 1'b0;
  string phase = "R9";

  always #2.5 clk = ~clk;

  dual_pwm #(.DUTY_W(DW), .SLOW_SHIFT(SS)) uut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // ---------------- reference model ----------------
  logic       mr1, mr2;
  logic [6:0] md;
  logic [7:0] mc;
  logic [5:0] mcfg;
  logic [3:0] movr;
  logic [3:0] mshd [2];
  logic [3:0] mact [2];
  logic       mpin [2];
  logic       e1, e2, e3;
  logic       t_tick, t_mon;
  logic [7:0] t_nxt;
  logic [3:0] t_fld;
  logic       t_bnd, t_slow;
  logic       n_pin [2];
  logic [3:0] n_act [2];
  logic [2:0] t_ps;
  int         t_msk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; md = 0; mc = 0; mcfg = 0; movr = 0;
      e1 = 0; e2 = 0; e3 = 0;
      for (int c = 0; c < 2; c++) begin mshd[c] = 0; mact[c] = 0; mpin[c] = 0; end
    end else if (!mr2) begin
      mr2 = mr1; mr1 = 1;
    end else begin
      t_ps = mcfg[2:0];
      if (t_ps != 3'd7) begin
        t_msk  = (1 << (t_ps + 1)) - 1;
        t_tick = ((int'(md) & t_msk) == t_msk);
        t_mon  = md[t_ps];
      end else begin
        t_tick = e2 & ~e3;
        t_mon  = e2;
      end
      t_nxt = mc + 8'd1;
      for (int c = 0; c < 2; c++) begin
        t_slow = mcfg[4 + c];
        t_fld  = t_slow ? mc[6:3] : mc[3:0];
        t_bnd  = t_slow ? (t_nxt[6:0] == 0) : (t_nxt[3:0] == 0);
        if (movr[2*c]) n_pin[c] = movr[2*c+1];
        else if (c == 0 && mcfg[3]) n_pin[c] = t_mon;
        else n_pin[c] = (t_fld < mact[c]);
        n_act[c] = (t_tick && t_bnd) ? mshd[c] : mact[c];
      end
      for (int c = 0; c < 2; c++) begin
        mpin[c] = n_pin[c];
        mact[c] = n_act[c];
        if (wr_en && wr_addr == 2'(2 + c)) mshd[c] = wr_data[3:0];
      end
      if (wr_en && wr_addr == 2'd0) mcfg = wr_data[5:0];
      if (wr_en && wr_addr == 2'd1) movr = wr_data[3:0];
      if (t_tick) mc = t_nxt;
      md = md + 7'd1;
      e3 = e2; e2 = e1; e1 = ext_clk;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (pwm_a !== mpin[0] || pwm_b !== mpin[1]) begin
        miscompares++;
        $display("FAIL %s: pins a/b got %b%b expected %b%b at %0t",
                 phase, pwm_a, pwm_b, mpin[0], mpin[1], $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic high_time(input bit chb, input int win, output int cnt);
    cnt = 0;
    repeat (win) begin
      @(negedge clk);
      if (chb ? pwm_b : pwm_a) cnt++;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  int duties [5] = '{0, 15, 7, 1, 9};

  initial begin
    int ht;
    int len;
    rst_n = 1'b0; ext_clk = 1'b0; wr_en = 1'b0; wr_addr = 0; wr_data = 0;
    idle(3);
    // R9 reset state
    check("R9 pwm_a in reset", int'(pwm_a), 0);
    check("R9 pwm_b in reset", int'(pwm_b), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    phase = "R9 R11";
    idle(8);

    // R1 R2 R3 R4 R5 R10: every divide tap, A short, B long, duties rewritten mid-period
    phase = "R1 R2 R3 R4 R5 R10 sweep";
    for (int s = 0; s < 7; s++) begin
      wr(2'd0, 8'(32 | s));
      len = 160 * (2 << s);
      for (int q = 0; q < 5; q++) begin
        wr(2'd2, 8'(duties[q]));
        wr(2'd3, 8'(duties[(q + 2) % 5]));
        idle(len / 5);
      end
    end

    // R3 R2 swapped modes on the faster taps
    phase = "R2 R3 R5 swapped";
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 8'(16 | s));
      len = 160 * (2 << s);
      for (int q = 0; q < 5; q++) begin
        wr(2'd2, 8'(duties[(q + 1) % 5]));
        wr(2'd3, 8'(duties[(q + 3) % 5]));
        idle(len / 5);
      end
    end

    // R1 R8 external clock, with and without clock-out
    phase = "R1 R8 external";
    wr(2'd0, 8'(32 | 7));
    wr(2'd2, 8'd5);
    wr(2'd3, 8'd2);
    fork
      begin
        repeat (500) begin
          idle(3);
          ext_clk = ~ext_clk;
        end
      end
      begin
        idle(700);
        wr(2'd0, 8'(32 | 8 | 7));
      end
    join

    // R6 R7 R8 every override pattern, clock-out off and on
    phase = "R6 R7 R8 overrides";
    wr(2'd2, 8'd6);
    wr(2'd3, 8'd11);
    for (int k = 0; k < 32; k++) begin
      wr(2'd0, 8'((k >= 16 ? 8 : 0) | 1));
      wr(2'd1, 8'(k % 16));
      idle(40);
    end
    wr(2'd1, 8'd0);

    // R2 fixed-window pulse width, short period, code 0: 5*2 of every 32 cycles
    phase = "R2 R3 measure";
    wr(2'd0, 8'd32);
    wr(2'd2, 8'd5);
    wr(2'd3, 8'd3);
    idle(600);
    high_time(1'b0, 128, ht);
    check("R2 short-period high time", ht, 40);
    // R3 long period, code 0: 3*8*2 of every 256 cycles
    high_time(1'b1, 256, ht);
    check("R3 long-period high time", ht, 48);

    // R8 clock-out on code 2: square wave of period 8
    wr(2'd0, 8'(8 | 2));
    idle(4);
    high_time(1'b0, 64, ht);
    check("R8 clock-out high time", ht, 32);

    // R6 force A high overrides clock-out
    wr(2'd1, 8'b0011);
    idle(3);
    high_time(1'b0, 20, ht);
    check("R6 forced level one", ht, 20);
    // R7 force B low
    wr(2'd1, 8'b0100);
    idle(3);
    high_time(1'b1, 64, ht);
    check("R7 forced level zero", ht, 0);

    // R4 zero duty stays low
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd0);
    wr(2'd2, 8'd0);
    idle(80);
    high_time(1'b0, 64, ht);
    check("R4 zero duty", ht, 0);

    cmp_on = 1'b0;
    summary();
  end

endmodule